// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the timing of a programmable video raster. It runs on the pixel clock and keeps a pixel counter and a line counter. Rising edges on the external horizontal sync, vertical sync and field-ID inputs lock these counters. When no edges arrive, the counters run freely. From the counter position the block drives separate horizontal and vertical sync pins, each with its own start, length and polarity. It also drives a select flag that says whether the current output word carries input data or a generated level.

Outside the data window, the block replaces the incoming word with generated codes. These are a blank level, plus negative and positive sync excursions. The sync shape depends on the kind of line: a normal sync pulse, which may be bi-level or tri-level; equalizing pulses at twice the line rate; or broad pulses separated by serration gaps. A pass mode lets a chosen range of blanking lines carry input data unchanged, so ancillary content flows through.

All timing values and level codes are written through a simple write port into a shadow bank. The shadow bank is copied into the working set only when a frame starts. The pixel stream has no valid/ready handshake because raster video is isochronous. One word enters on every clock, one word leaves on every clock, and there is no back-pressure. Every output is registered and follows its inputs by exactly one clock.

Top module: `vtg_top`

## Requirements
- R1: Each clock the pixel counter steps by one and returns to 0 after the value HTOT-1. At that wrap the line counter steps by one and returns to 0 after VTOT-1. When no sync edges arrive, both counters run freely.
- R2: A rising edge on hs_in loads the pixel counter with HPRE instead of stepping, and that line does not end. A rising edge on vs_in clears the line counter. Each frame start latches fid_in as the current field.
- R3: All outputs are registered. Each is computed from the counter state and pix_in present before a clock edge and appears right after that edge.
- R4: data_sel is 1 when the pixel lies in [AHS,AHE) and the line is in the active range. In field 1 with MODE bit 4 set, the active range is [AVS1,AVE1); otherwise it is [AVS0,AVE0). data_sel is also 1 in [AHS,AHE) on lines in [PSF,PSL) when MODE bit 3 is set. While data_sel is 1, pix_out equals pix_in.
- R5: While data_sel is 0 and no sync excursion is due, pix_out equals the BLANK code.
- R6: On normal lines, pixels in [SST,SST+SWD) give the NEG code. With MODE bit 2 set (tri-level), the next SWD pixels give the POS code and then the output returns to blank.
- R7: Lines in [BRF,BRL) are broad lines and take precedence over lines in [EQF,EQL), which are equalizing lines. On both kinds, a pulse of NEG code starts at SST and again at SST+HTOT/2 (HTOT/2 rounded down). Its width is BRW on broad lines and EQW on equalizing lines, which leaves a serration gap of HTOT/2-BRW on broad lines.
- R8: hsync_out is (pixel in [HOS,HOS+HOW)) XOR MODE bit 0. vsync_out is (line in [VOS,VOS+VOW)) XOR MODE bit 1.
- R9: A write only changes the shadow bank. The working set takes the whole shadow bank at a frame start: a vs_in rising edge, or the end of the last pixel of line VTOT-1. A write in the same cycle as a frame start waits for the next one.
- R10: Reset clears every register in both banks and drives all outputs to 0.
- R11: Write port addresses: 0 HTOT, 1 VTOT, 2 HPRE, 3 SST, 4 SWD, 5 AHS, 6 AHE, 7 AVS0, 8 AVE0, 9 AVS1, 10 AVE1, 11 PSF, 12 PSL, 13 EQF, 14 EQL, 15 EQW, 16 BRF, 17 BRL, 18 BRW, 19 HOS, 20 HOW, 21 VOS, 22 VOW, 23 MODE, 24 BLANK, 25 NEG, 26 POS. Writes to any other address are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | External horizontal sync, rising edge locks the pixel counter |
| vs_in | input | 1 | External vertical sync, rising edge clears the line counter |
| fid_in | input | 1 | External field identifier, latched at frame start |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 5 | Shadow register address |
| cfg_wdata | input | CW | Shadow register write value |
| pix_in | input | DW | Incoming pixel word, one per clock |
| pix_out | output | DW | Outgoing word: input data or generated level |
| data_sel | output | 1 | 1 when pix_out carries input data |
| hsync_out | output | 1 | Programmable horizontal sync pin |
| vsync_out | output | 1 | Programmable vertical sync pin |

## Verification
The assertions assume that hs_in, vs_in and fid_in are synchronous to the pixel clock. They also assume the level codes fit in DW bits. Window starts and lengths are taken to be small enough that start plus length does not wrap the CW-bit range. The stimulus keeps every programmed window inside a line of 32 to 63 pixels and 10 to 19 lines. Sync pulses on hs_in and vs_in are sparse and last one cycle, and all inputs change on the falling clock edge.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NREG   = 27;
  localparam int A_HTOT = 0;
  localparam int A_VTOT = 1;
  localparam int A_HPRE = 2;
  localparam int A_SST  = 3;
  localparam int A_SWD  = 4;
  localparam int A_AHS  = 5;
  localparam int A_AHE  = 6;
  localparam int A_AVS0 = 7;
  localparam int A_AVE0 = 8;
  localparam int A_AVS1 = 9;
  localparam int A_AVE1 = 10;
  localparam int A_PSF  = 11;
  localparam int A_PSL  = 12;
  localparam int A_EQF  = 13;
  localparam int A_EQL  = 14;
  localparam int A_EQW  = 15;
  localparam int A_BRF  = 16;
  localparam int A_BRL  = 17;
  localparam int A_BRW  = 18;
  localparam int A_HOS  = 19;
  localparam int A_HOW  = 20;
  localparam int A_VOS  = 21;
  localparam int A_VOW  = 22;
  localparam int A_MODE = 23;
  localparam int A_BLNK = 24;
  localparam int A_NEG  = 25;
  localparam int A_POS  = 26;

  localparam int M_HPOL  = 0;
  localparam int M_VPOL  = 1;
  localparam int M_TRI   = 2;
  localparam int M_PASS  = 3;
  localparam int M_ILACE = 4;

  typedef enum logic [1:0] {
    LK_NORMAL = 2'd0,
    LK_EQUAL  = 2'd1,
    LK_BROAD  = 2'd2
  } line_kind_e;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [CW-1:0]            wdata,
  input  logic                     frame_start,
  output logic [NREG-1:0][CW-1:0]  act
);
  logic [NREG-1:0][CW-1:0] shd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
      act <= '0;
    end else begin
      if (frame_start) act <= shd;
      if (we && (addr < AW'(NREG))) shd[addr] <= wdata;
    end
  end

  // R9: the working set only moves at a frame start
  p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act));
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          fid_in,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  input  logic [CW-1:0] hpre,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          field,
  output logic          frame_start
);
  logic hs_d, vs_d;
  logic h_edge, v_edge, h_last, v_last, line_end;

  always_comb begin
    h_edge      = hs_in & ~hs_d;
    v_edge      = vs_in & ~vs_d;
    h_last      = (h_cnt == htot - CW'(1));
    v_last      = (v_cnt == vtot - CW'(1));
    line_end    = h_last & ~h_edge;
    frame_start = v_edge | (line_end & v_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d  <= 1'b0;
      vs_d  <= 1'b0;
      h_cnt <= '0;
      v_cnt <= '0;
      field <= 1'b0;
    end else begin
      hs_d <= hs_in;
      vs_d <= vs_in;
      if (h_edge)      h_cnt <= hpre;
      else if (h_last) h_cnt <= '0;
      else             h_cnt <= h_cnt + CW'(1);
      if (v_edge)        v_cnt <= '0;
      else if (line_end) v_cnt <= v_last ? '0 : v_cnt + CW'(1);
      if (frame_start) field <= fid_in;
    end
  end

  // R2: external horizontal edge preloads the pixel counter
  p_h_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_edge |=> (h_cnt == $past(hpre)));
  // R2: external vertical edge restarts the frame at line 0
  p_v_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (v_cnt == '0));
  // R1: the line counter holds except at a line end
  p_line_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_end && !v_edge) |=> $stable(v_cnt));
endmodule

// File: rtl/vtg_pixel.sv
module vtg_pixel
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            h_cnt,
  input  logic [CW-1:0]            v_cnt,
  input  logic                     field,
  input  logic [NREG-1:0][CW-1:0]  act,
  input  logic [DW-1:0]            pix_in,
  output logic [DW-1:0]            pix_out,
  output logic                     data_sel,
  output logic                     hsync_out,
  output logic                     vsync_out
);
  function automatic logic in_range(input logic [CW-1:0] x, lo, hi);
    return (x >= lo) && (x < hi);
  endfunction

  function automatic logic in_win(input logic [CW-1:0] x, st, len);
    return ({1'b0, x} >= {1'b0, st}) && ({1'b0, x} < ({1'b0, st} + {1'b0, len}));
  endfunction

  logic [CW-1:0] mode, half, rel, fold;
  line_kind_e    kind;
  logic          v_act, v_pass, sel_c, past_ss, neg_c, pos_c, hs_c, vs_c;
  logic [DW-1:0] word_c;
  logic          unused_bits;

  assign unused_bits = ^{act[A_VTOT], act[A_HPRE], act[A_HTOT][0], mode[CW-1:5],
                         act[A_BLNK][CW-1:DW], act[A_NEG][CW-1:DW], act[A_POS][CW-1:DW]};

  always_comb begin
    mode    = act[A_MODE];
    half    = {1'b0, act[A_HTOT][CW-1:1]};
    if (mode[M_ILACE] && field) v_act = in_range(v_cnt, act[A_AVS1], act[A_AVE1]);
    else                        v_act = in_range(v_cnt, act[A_AVS0], act[A_AVE0]);
    v_pass  = mode[M_PASS] && in_range(v_cnt, act[A_PSF], act[A_PSL]);
    sel_c   = in_range(h_cnt, act[A_AHS], act[A_AHE]) && (v_act || v_pass);

    if (in_range(v_cnt, act[A_BRF], act[A_BRL]))      kind = LK_BROAD;
    else if (in_range(v_cnt, act[A_EQF], act[A_EQL])) kind = LK_EQUAL;
    else                                              kind = LK_NORMAL;

    past_ss = (h_cnt >= act[A_SST]);
    rel     = h_cnt - act[A_SST];
    fold    = (rel >= half) ? rel - half : rel;
    neg_c   = 1'b0;
    pos_c   = 1'b0;
    if (past_ss) begin
      unique case (kind)
        LK_BROAD: neg_c = (fold < act[A_BRW]);
        LK_EQUAL: neg_c = (fold < act[A_EQW]);
        default: begin
          neg_c = (rel < act[A_SWD]);
          pos_c = mode[M_TRI] && !neg_c && ({1'b0, rel} < {act[A_SWD], 1'b0});
        end
      endcase
    end

    if (sel_c)      word_c = pix_in;
    else if (neg_c) word_c = act[A_NEG][DW-1:0];
    else if (pos_c) word_c = act[A_POS][DW-1:0];
    else            word_c = act[A_BLNK][DW-1:0];

    hs_c = in_win(h_cnt, act[A_HOS], act[A_HOW]) ^ mode[M_HPOL];
    vs_c = in_win(v_cnt, act[A_VOS], act[A_VOW]) ^ mode[M_VPOL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out   <= '0;
      data_sel  <= 1'b0;
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
    end else begin
      pix_out   <= word_c;
      data_sel  <= sel_c;
      hsync_out <= hs_c;
      vsync_out <= vs_c;
    end
  end

  // R4: selected words are the input word of the previous cycle
  p_pass_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_sel |-> (pix_out == $past(pix_in)));
  // R5: unselected words are always one of the generated level codes
  p_gen_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_sel |-> ((pix_out == $past(act[A_BLNK][DW-1:0])) ||
                   (pix_out == $past(act[A_NEG][DW-1:0]))  ||
                   (pix_out == $past(act[A_POS][DW-1:0]))));
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 10,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          fid_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] pix_out,
  output logic          data_sel,
  output logic          hsync_out,
  output logic          vsync_out
);
  logic [NREG-1:0][CW-1:0] act;
  logic [CW-1:0]           h_cnt, v_cnt;
  logic                    field, frame_start;

  vtg_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start), .act(act)
  );

  vtg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .htot(act[A_HTOT]), .vtot(act[A_VTOT]), .hpre(act[A_HPRE]),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field), .frame_start(frame_start)
  );

  vtg_pixel #(.CW(CW), .DW(DW)) u_pix (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field),
    .act(act), .pix_in(pix_in), .pix_out(pix_out), .data_sel(data_sel),
    .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  // R3: with the sync pin window empty, the pin shows the polarity bit of the previous cycle
  p_hs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act[A_HOW]) == '0) |-> (hsync_out == $past(act[A_MODE][M_HPOL])));
endmodule

// File: tb/test_vtg_top.sv
`timescale 1ns/1ps
module test_vtg_top;
  import vtg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs_in = 1'b0, vs_in = 1'b0, fid_in = 1'b0, cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [9:0]  pix_in = '0;
  logic [9:0]  pix_out;
  logic        data_sel, hsync_out, vsync_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int ms[NREG], ma[NREG], cfg[NREG];
  int mh = 0, mv = 0;
  bit mfield = 0, mhs_d = 0, mvs_d = 0;
  int e_pix;
  bit e_sel, e_hs, e_vs;
  string e_tag;

  always #2.5 clk = ~clk;

  vtg_top i_vtg_top (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pix_in(pix_in),
    .pix_out(pix_out), .data_sel(data_sel), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit inr(input int x, input int lo, input int hi);
    return (x >= lo) && (x < hi);
  endfunction

  // Reference model of one clock edge, built from the requirements
  task automatic model_step(input bit hs, input bit vs, input bit fid, input bit we,
                            input int addr, input int wdata, input int pin);
    bit hedge, vedge, vact, vpass, neg, pos, hlast, lend, vlast, fs;
    int md, half, rel, fold;
    md    = ma[A_MODE];
    hedge = hs && !mhs_d;
    vedge = vs && !mvs_d;
    if (md[M_ILACE] && mfield) vact = inr(mv, ma[A_AVS1], ma[A_AVE1]);
    else                       vact = inr(mv, ma[A_AVS0], ma[A_AVE0]);
    vpass = md[M_PASS] && inr(mv, ma[A_PSF], ma[A_PSL]);
    e_sel = inr(mh, ma[A_AHS], ma[A_AHE]) && (vact || vpass);
    half  = ma[A_HTOT] / 2;
    neg = 0; pos = 0;
    e_tag = "R5";
    if (mh >= ma[A_SST]) begin
      rel  = mh - ma[A_SST];
      fold = (rel >= half) ? rel - half : rel;
      if (inr(mv, ma[A_BRF], ma[A_BRL]))      begin neg = fold < ma[A_BRW]; e_tag = "R7"; end
      else if (inr(mv, ma[A_EQF], ma[A_EQL])) begin neg = fold < ma[A_EQW]; e_tag = "R7"; end
      else begin
        neg = rel < ma[A_SWD];
        pos = md[M_TRI] && !neg && (rel < 2 * ma[A_SWD]);
        if (neg || pos) e_tag = "R6";
      end
    end
    if (!neg && !pos && e_tag != "R6") e_tag = (e_tag == "R7" && !neg) ? "R7" : e_tag;
    if (e_sel) begin e_pix = pin; e_tag = "R4"; end
    else if (neg) e_pix = ma[A_NEG] & 1023;
    else if (pos) e_pix = ma[A_POS] & 1023;
    else          e_pix = ma[A_BLNK] & 1023;
    e_hs = inr(mh, ma[A_HOS], ma[A_HOS] + ma[A_HOW]) ^ md[M_HPOL];
    e_vs = inr(mv, ma[A_VOS], ma[A_VOS] + ma[A_VOW]) ^ md[M_VPOL];
    hlast = (mh == ((ma[A_HTOT] - 1) & 4095));
    vlast = (mv == ((ma[A_VTOT] - 1) & 4095));
    lend  = hlast && !hedge;
    fs    = vedge || (lend && vlast);
    if (fs) mfield = fid;
    if (hedge)      mh = ma[A_HPRE];
    else if (hlast) mh = 0;
    else            mh = (mh + 1) & 4095;
    if (vedge)     mv = 0;
    else if (lend) mv = vlast ? 0 : ((mv + 1) & 4095);
    if (fs) ma = ms;
    if (we && addr < NREG) ms[addr] = wdata & 4095;
    mhs_d = hs;
    mvs_d = vs;
  endtask

  task automatic cyc(input bit hs, input bit vs, input bit fid, input bit we,
                     input int addr, input int wdata);
    logic [9:0] p;
    p = 10'($urandom);
    hs_in = hs; vs_in = vs; fid_in = fid; cfg_we = we;
    cfg_addr = 5'(addr); cfg_wdata = 12'(wdata); pix_in = p;
    model_step(hs, vs, fid, we, addr, wdata, int'(p));
    @(posedge clk);
    @(negedge clk);
    check({"data_sel R4/R3/R9/R11"}, data_sel, e_sel);
    check({"pix_out ", e_tag, "/R3/R9/R11"}, pix_out, e_pix);
    check("hsync_out R8/R1/R2", hsync_out, e_hs);
    check("vsync_out R8/R1/R2", vsync_out, e_vs);
  endtask

  function automatic int rnd(input int n);
    return int'($urandom % n);
  endfunction

  task automatic make_cfg();
    int ht, vt, ahs;
    ht = 32 + rnd(32); vt = 10 + rnd(10);
    cfg[A_HTOT] = ht;           cfg[A_VTOT] = vt;
    cfg[A_HPRE] = rnd(ht);      cfg[A_SST]  = 2 + rnd(4);
    cfg[A_SWD]  = 2 + rnd(3);
    ahs = cfg[A_SST] + 2 * cfg[A_SWD] + 1 + rnd(3);
    cfg[A_AHS]  = ahs;          cfg[A_AHE]  = ahs + 4 + rnd(8);
    cfg[A_AVS0] = 2 + rnd(3);   cfg[A_AVE0] = vt - 1 - rnd(2);
    cfg[A_AVS1] = cfg[A_AVS0] + 1; cfg[A_AVE1] = cfg[A_AVE0];
    cfg[A_PSF]  = rnd(2);       cfg[A_PSL]  = cfg[A_PSF] + 1 + rnd(2);
    cfg[A_EQF]  = rnd(2);       cfg[A_EQL]  = cfg[A_EQF] + 1 + rnd(2);
    cfg[A_EQW]  = 1 + rnd(3);
    cfg[A_BRF]  = rnd(3);       cfg[A_BRL]  = cfg[A_BRF] + rnd(2);
    cfg[A_BRW]  = ht / 2 - 2 - rnd(3);
    cfg[A_HOS]  = rnd(ht);      cfg[A_HOW]  = 1 + rnd(6);
    cfg[A_VOS]  = rnd(vt);      cfg[A_VOW]  = 1 + rnd(3);
    cfg[A_MODE] = rnd(32);
    cfg[A_BLNK] = 64 + rnd(64); cfg[A_NEG]  = rnd(32);
    cfg[A_POS]  = 512 + rnd(400);
  endtask

  task automatic load_cfg(input bit fid);
    for (int a = 0; a < NREG; a++) cyc(0, 0, fid, 1, a, cfg[a]);
    cyc(0, 0, fid, 1, 30, 4095); // R11: out-of-map address has no effect
  endtask

  task automatic run(input int n, input bit fid, input int hs_rate, input int vs_rate);
    for (int i = 0; i < n; i++) begin
      bit h, v;
      h = (hs_rate != 0) && (rnd(hs_rate) == 0) && !hs_in;
      v = (vs_rate != 0) && (rnd(vs_rate) == 0) && !vs_in;
      cyc(h, v, fid, 0, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int a = 0; a < NREG; a++) begin ms[a] = 0; ma[a] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("reset pix_out R10", pix_out, 0);
    check("reset data_sel R10", data_sel, 0);
    check("reset hsync_out R10", hsync_out, 0);
    check("reset vsync_out R10", vsync_out, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    check("post-reset idle pix_out R10", pix_out, 0);

    // Directed: tri-level sync, no equalizing or broad lines, free running (R6, R1)
    make_cfg();
    cfg[A_HTOT] = 40; cfg[A_VTOT] = 12; cfg[A_SST] = 3; cfg[A_SWD] = 4;
    cfg[A_AHS] = 14;  cfg[A_AHE] = 36;  cfg[A_EQF] = 0; cfg[A_EQL] = 0;
    cfg[A_BRF] = 0;   cfg[A_BRL] = 0;   cfg[A_MODE] = 32'h04;
    load_cfg(0);
    cyc(0, 1, 0, 0, 0, 0);
    run(40 * 12 * 2 + 7, 0, 0, 0);

    // Directed: pass lines plus interlace field 1, applied by vs edge (R4, R2)
    make_cfg();
    cfg[A_MODE] = 32'h18;
    load_cfg(1);
    cyc(0, 1, 1, 0, 0, 0);
    run(cfg[A_HTOT] * cfg[A_VTOT] * 2, 1, 0, 0);

    // Constrained random configurations
    for (int k = 0; k < 16; k++) begin
      bit f;
      f = bit'(rnd(2));
      make_cfg();
      load_cfg(f);
      if (k % 2 == 0) cyc(0, 1, f, 0, 0, 0);   // R9: apply by vs edge
      run(cfg[A_HTOT] * cfg[A_VTOT] * 3, f, (k % 3 == 0) ? 0 : 150, (k % 4 == 1) ? 1500 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(180000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule